// File: doc/BRIEF.md
# Noise-Gated Audio Level Meter

This block turns a stream of 16-bit two's-complement audio samples into a bar-graph level display on 16 LEDs, in the manner of a stereo level indicator. Each sample arrives with a one-cycle valid strobe. The block takes the sample's magnitude. It forces small idle-channel magnitudes to zero. It then lights a contiguous run of LEDs, starting at LED 0, whose length rises with the magnitude.

The gate looks at the magnitude, not at the signed value. In two's complement a small negative noise sample such as -3 is almost all 1 bits. A display fed with raw bits would glow whenever the channel is quiet. Working on the magnitude keeps a silent channel dark, whatever the sign of the noise. The display is registered and changes only when a new sample is strobed in.

Top module: `lvl_meter`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is asserted, `led` is all zeros.
- R2: The display depends only on the sample's magnitude: a negative sample -x gives the same `led` value as +x, for 1 <= x <= 32767.
- R3: The sample -32768 (16'h8000) is treated as magnitude 32767 and lights all 16 LEDs.
- R4: A sample whose magnitude is below the gate threshold (parameter, default 7) gives `led` = 0. This covers idle noise from -6 to +6.
- R5: A sample whose magnitude m is at or above the threshold lights floor(m / 2048) + 1 LEDs. This means 16 equal bands taken from the upper four bits of the 15-bit magnitude.
- R6: `led` is always a thermometer code: LEDs 0 to n-1 are on and all higher LEDs are off, where n is the lit count.
- R7: `led` takes the value for a sample on the rising clock edge where `sample_valid` is high, with one register of latency. It holds its value on every edge where `sample_valid` is low, whatever `sample` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | 16 | Two's-complement audio sample |
| sample_valid | input | 1 | High for one cycle when `sample` holds a new sample |
| led | output | 16 | Bar-graph LED vector, bit 0 is the first lit LED |

## Verification
The corners that are hardest to reach are the single codes where the meter's arithmetic changes. These are the one value whose negation does not fit, the two edges of the gate on either side of zero, and the 2048-wide band boundaries. A random audio-like stimulus would almost never land on these exact codes. The bench therefore sweeps every one of the 65,536 input codes in turn, strobed on consecutive cycles. It compares each displayed bar with a count that it derives arithmetically from the integer value. Separate phases then present samples with the strobe low, and pulse reset in the middle of a run, to show that the display holds or clears as required.

// File: rtl/lvl_meter_pkg.sv
package lvl_meter_pkg;

  // Number of lit segments for a gated magnitude: zero stays dark,
  // anything else lands in band (gmag >> shift) and lights band+1.
  function automatic int unsigned bar_len(input int unsigned gmag,
                                          input int unsigned shift);
    if (gmag == 0) return 0;
    return (gmag >> shift) + 1;
  endfunction

endpackage

// File: rtl/lvl_abs.sv
module lvl_abs #(
  parameter int SW = 16
) (
  input  logic [SW-1:0] smp,
  output logic [SW-2:0] mag
);
  localparam logic [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};

  logic [SW-1:0] negated;

  always_comb begin
    negated = -smp;
    if (smp == MOST_NEG)   mag = '1;
    else if (smp[SW-1])    mag = negated[SW-2:0];
    else                   mag = smp[SW-2:0];
  end
endmodule

// File: rtl/lvl_gate.sv
module lvl_gate #(
  parameter int MW = 15,
  parameter int TH = 7
) (
  input  logic [MW-1:0] mag,
  output logic          pass,
  output logic [MW-1:0] gmag
);
  always_comb begin
    pass = (mag >= MW'(TH));
    gmag = pass ? mag : '0;
  end
endmodule

// File: rtl/lvl_bar.sv
module lvl_bar
  import lvl_meter_pkg::*;
#(
  parameter int MW    = 15,
  parameter int LED_N = 16
) (
  input  logic [MW-1:0]                gmag,
  output logic [$clog2(LED_N):0]       cnt,
  output logic [LED_N-1:0]             therm
);
  localparam int BW = $clog2(LED_N);
  localparam int CW = BW + 1;
  localparam int SH = MW - BW;

  always_comb begin
    cnt = CW'(bar_len(32'(gmag), SH));
  end

  for (genvar i = 0; i < LED_N; i++) begin : g_seg
    assign therm[i] = (cnt > CW'(i));
  end
endmodule

// File: rtl/lvl_meter.sv
module lvl_meter #(
  parameter int SW      = 16,
  parameter int LED_N   = 16,
  parameter int GATE_TH = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] sample,
  input  logic          sample_valid,
  output logic [LED_N-1:0] led
);
  localparam int MW = SW - 1;
  localparam int CW = $clog2(LED_N) + 1;

  logic [MW-1:0]    mag;
  logic             pass;
  logic [MW-1:0]    gmag;
  logic [CW-1:0]    cnt;
  logic [LED_N-1:0] therm;

  lvl_abs #(.SW(SW)) u_abs (.smp(sample), .mag(mag));

  lvl_gate #(.MW(MW), .TH(GATE_TH)) u_gate (
    .mag(mag), .pass(pass), .gmag(gmag)
  );

  lvl_bar #(.MW(MW), .LED_N(LED_N)) u_bar (
    .gmag(gmag), .cnt(cnt), .therm(therm)
  );

  always_ff @(posedge clk) begin
    if (rst)               led <= '0;
    else if (sample_valid) led <= therm;
  end
endmodule

// File: rtl/lvl_meter_chk.sv
module lvl_meter_chk #(
  parameter int SW      = 16,
  parameter int LED_N   = 16,
  parameter int GATE_TH = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [SW-1:0]    sample,
  input logic             sample_valid,
  input logic [LED_N-1:0] led,
  input logic [SW-2:0]    mag,
  input logic             pass
);
  localparam logic [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};

  a_r1_reset_dark: assert property (@(posedge clk) rst |=> (led == '0));

  a_r2_pos_mag: assert property (@(posedge clk) disable iff (rst)
    (!sample[SW-1]) |-> (mag == sample[SW-2:0]));

  a_r3_most_neg_full: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && sample == MOST_NEG) |=> (&led));

  a_r4_gate_dark: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && !pass) |=> (led == '0));

  a_r5_open_lit: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && pass && mag != '0) |=> led[0]);

  a_r6_thermo: assert property (@(posedge clk) disable iff (rst)
    ((led & (led + 1'b1)) == '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!sample_valid) |=> $stable(led));
endmodule

bind lvl_meter lvl_meter_chk #(.SW(SW), .LED_N(LED_N), .GATE_TH(GATE_TH)) u_chk (
  .clk(clk), .rst(rst), .sample(sample), .sample_valid(sample_valid),
  .led(led), .mag(mag), .pass(pass)
);

// File: tb/lvl_meter_tb.sv
module lvl_meter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TH = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sample = '0;
  logic        sample_valid = 1'b0;
  logic [15:0] led;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  lvl_meter #(.SW(16), .LED_N(16), .GATE_TH(TH)) u_dut (
    .clk(clk), .rst(rst), .sample(sample),
    .sample_valid(sample_valid), .led(led)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ref_bar(input int s);
    int a;
    int n;
    a = (s < 0) ? -s : s;
    if (a > 32767) a = 32767;
    n = (a < TH) ? 0 : (a / 2048) + 1;
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    n_run++;
    if (led !== exp) begin
      n_fail++;
      $display("FAIL %s: led=%h expected=%h", req, led, exp);
    end
  endtask

  // called at a negedge: present, let the edge pass, check at the next negedge
  task automatic put(input int s, input bit v);
    sample = 16'(s);
    sample_valid = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 16'h0000);
    rst = 1'b0;

    // R4: gate edges on both sides of zero
    put(0, 1);       check("R4", 16'h0000);
    put(6, 1);       check("R4", 16'h0000);
    put(-6, 1);      check("R4", 16'h0000);
    put(TH, 1);      check("R5", 16'h0001);
    put(-TH, 1);     check("R2", 16'h0001);
    // R5: band boundaries
    put(2047, 1);    check("R5", 16'h0001);
    put(2048, 1);    check("R5", 16'h0003);
    put(32767, 1);   check("R5", 16'hFFFF);
    put(-32767, 1);  check("R2", 16'hFFFF);
    // R3
    put(-32768, 1);  check("R3", 16'hFFFF);
    // R7: strobe low holds display
    put(5, 0);       check("R7", 16'hFFFF);
    put(-20000, 0);  check("R7", 16'hFFFF);
    put(10000, 1);   check("R7", ref_bar(10000));
    put(0, 0);       check("R7", ref_bar(10000));
    // R1: reset mid-run
    rst = 1'b1;
    put(30000, 1);   check("R1", 16'h0000);
    rst = 1'b0;

    // Exhaustive sweep, R2..R6
    for (int s = -32768; s <= 32767; s++) begin
      logic [15:0] e;
      string tag;
      e = ref_bar(s);
      if (s == -32768)          tag = "R3";
      else if (s < TH && s > -TH) tag = "R4";
      else if (s < 0)           tag = "R2";
      else                      tag = "R5";
      put(s, 1);
      check(tag, e);
      if (((led + 16'd1) & led) != 16'd0) begin
        n_run++; n_fail++;
        $display("FAIL R6: led=%h expected=thermometer code", led);
      end
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run=timeout expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule